// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block holds three alarm registers, one each for seconds, minutes and hours. It compares them with a running BCD time of day. Each register byte carries two things. The ones digit sits in bits 3:0 and the tens digit sits above it. Bit 7 is a mask bit: when it is set, that field is left out of the comparison and always counts as equal.

The comparison is taken only on the clock cycle in which the one-cycle seconds pulse is high. When every field that is not masked equals the current time, a sticky alarm flag is raised. The flag stays up until software acknowledges it with a flag-read strobe, or until reset. An interrupt output follows the flag while an enable input is high.

Software loads a register through a simple write port. The write selects one of the three fields by a two-bit code. The timekeeping counters and the bus that reads the flag live outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `alarmFlag` and `alarmIrq` are 0. All three alarm registers hold 0x00: unmasked and set to zero, so a tick at 00:00:00 sets the flag.
- R2: When `wrEn` is high, `wrData` is loaded into the register chosen by `wrSel`: 0 for seconds, 1 for minutes, 2 for hours. `wrSel` = 3 changes no register.
- R3: On a cycle with `secTick` high, the flag is set at the next clock edge when every unmasked field is equal. For seconds and minutes, equal means bits 6:0 of the register equal bits 6:0 of the time input. For hours, bits 5:0 are compared.
- R4: A register with bit 7 = 1 is left out of the comparison: its field is treated as equal whatever the time value.
- R5: With all three mask bits at 1, every `secTick` sets the flag.
- R6: Without `secTick`, the flag never rises, even while the time equals the alarm.
- R7: Once set, the flag stays at 1 until a cycle with `flagRead` high. After that cycle it is 0, unless R8 applies.
- R8: When a qualifying match and `flagRead` fall in the same cycle, the flag is 1 afterwards.
- R9: `alarmIrq` is 1 exactly while `alarmFlag` and `irqEnable` are both 1.
- R10: Bit 6 of the hours register and bit 6 of `curHour` take no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse marking a new second |
| curSec | input | 8 | Current seconds, BCD (tens in 6:4, ones in 3:0) |
| curMin | input | 8 | Current minutes, BCD (tens in 6:4, ones in 3:0) |
| curHour | input | 8 | Current hours, BCD (tens in 5:4, ones in 3:0) |
| wrEn | input | 1 | Alarm register write strobe |
| wrSel | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours, 3 none |
| wrData | input | 8 | Register value: bit 7 mask, lower bits BCD alarm digits |
| flagRead | input | 1 | Flag acknowledge strobe, clears the flag |
| irqEnable | input | 1 | Alarm interrupt enable |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIrq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach from the ports is a collision: a qualifying match and an acknowledge must land in the same cycle. The bench therefore drives `secTick` and `flagRead` on the same clock, both while the flag is already set and while it is clear.

A second hard area is the full set of mask and match combinations. The bench walks through all eight mask patterns against all eight patterns of which fields match, and computes the expected flag from them. It also sweeps the seconds input across 0 to 59, so that near-miss digit values are tried against one unmasked seconds alarm.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

  // Number of compared time fields: seconds, minutes, hours.
  localparam int NUM_FIELDS = 3;
  localparam int SEL_W      = 2;

  localparam int SEC_IDX  = 0;
  localparam int MIN_IDX  = 1;
  localparam int HOUR_IDX = 2;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic [NUM_FIELDS-1:0] loadField;  // one-hot register load
    logic                  evalNow;    // take the comparison this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/alarm_match_datapath.sv
module alarm_match_datapath
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int MASK_POS = FIELD_W - 1,
  parameter logic [FIELD_W-1:0] FULL_CMP = 8'h7F,
  parameter logic [FIELD_W-1:0] HOUR_CMP = 8'h3F
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [FIELD_W-1:0]            wrData,
  input  logic [NUM_FIELDS*FIELD_W-1:0] timeFlat,
  output logic                          hitNow
);

  logic [NUM_FIELDS-1:0] fieldOk;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam logic [FIELD_W-1:0] CMP_BITS = (f == HOUR_IDX) ? HOUR_CMP : FULL_CMP;

    logic [FIELD_W-1:0] alarmReg;
    logic [FIELD_W-1:0] diffBits;
    logic               maskBit;
    logic               valueEq;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        alarmReg <= '0;
      end else if (strobes.loadField[f]) begin
        alarmReg <= wrData;
      end
    end

    always_comb begin
      diffBits = (alarmReg ^ timeFlat[f*FIELD_W +: FIELD_W]) & CMP_BITS;
      valueEq  = (diffBits == '0);
      maskBit  = alarmReg[MASK_POS];
      fieldOk[f] = maskBit | valueEq;
    end
  end

  assign hitNow = strobes.evalNow & (&fieldOk);

endmodule

// File: rtl/alarm_match_control.sv
module alarm_match_control
  import alarm_match_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             flagRead,
  input  logic             irqEnable,
  input  logic             hitNow,
  output ctrlStrobes_t     strobes,
  output logic             alarmFlag,
  output logic             alarmIrq
);

  logic flagQ;

  always_comb begin
    strobes.evalNow = secTick;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      strobes.loadField[f] = wrEn && (wrSel == SEL_W'(f));
    end
  end

  // A set in the same cycle as an acknowledge takes priority.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (hitNow) begin
      flagQ <= 1'b1;
    end else if (flagRead) begin
      flagQ <= 1'b0;
    end
  end

  assign alarmFlag = flagQ;
  assign alarmIrq  = flagQ & irqEnable;

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               secTick,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curHour,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [FIELD_W-1:0] wrData,
  input  logic               flagRead,
  input  logic               irqEnable,
  output logic               alarmFlag,
  output logic               alarmIrq
);

  ctrlStrobes_t                  strobes;
  logic                          hitNow;
  logic [NUM_FIELDS*FIELD_W-1:0] timeFlat;

  assign timeFlat = {curHour, curMin, curSec};

  alarm_match_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .secTick   (secTick),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .flagRead  (flagRead),
    .irqEnable (irqEnable),
    .hitNow    (hitNow),
    .strobes   (strobes),
    .alarmFlag (alarmFlag),
    .alarmIrq  (alarmIrq)
  );

  alarm_match_datapath #(
    .FIELD_W (FIELD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .timeFlat (timeFlat),
    .hitNow   (hitNow)
  );

endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker
  import alarm_match_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               secTick,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrSel,
  input logic [FIELD_W-1:0] wrData,
  input logic               flagRead,
  input logic               irqEnable,
  input logic               alarmFlag,
  input logic               alarmIrq
);

  // Mask bits as seen from the write port.
  logic [NUM_FIELDS-1:0] maskSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskSeen <= '0;
    end else if (wrEn && (wrSel < SEL_W'(NUM_FIELDS))) begin
      maskSeen[wrSel] <= wrData[FIELD_W-1];
    end
  end

  assert_no_spurious_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> !$rose(alarmFlag));

  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !flagRead) |=> alarmFlag);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !secTick) |=> !alarmFlag);

  assert_all_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && (&maskSeen)) |=> alarmFlag);

  // R8: set wins over an acknowledge in the same cycle
  assert_set_beats_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && (&maskSeen) && flagRead) |=> alarmFlag);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !alarmIrq);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> alarmFlag);

endmodule

bind alarm_match_unit alarm_match_checker #(.FIELD_W(FIELD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .secTick   (secTick),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrData    (wrData),
  .flagRead  (flagRead),
  .irqEnable (irqEnable),
  .alarmFlag (alarmFlag),
  .alarmIrq  (alarmIrq)
);

// File: tb/alarm_match_unit_test.sv
`timescale 1ns/1ps
module alarm_match_unit_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       secTick;
  logic [7:0] curSec, curMin, curHour;
  logic       wrEn;
  logic [1:0] wrSel;
  logic [7:0] wrData;
  logic       flagRead;
  logic       irqEnable;
  logic       alarmFlag, alarmIrq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  alarm_match_unit uut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .flagRead(flagRead), .irqEnable(irqEnable),
    .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One cycle with the given strobes; the result is visible at the next negedge.
  task automatic pulse(input logic tick, input logic rd);
    @(negedge clk);
    secTick = tick; flagRead = rd;
    @(negedge clk);
    secTick = 1'b0; flagRead = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    curHour = h; curMin = m; curSec = s;
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; secTick = 1'b0; wrEn = 1'b0; wrSel = 2'd0; wrData = 8'h00;
    flagRead = 1'b0; irqEnable = 1'b1;
    setTime(8'h00, 8'h00, 8'h01);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state and zero-valued, unmasked registers
    check("R1 flag after reset", alarmFlag, 1'b0);
    check("R1 irq after reset", alarmIrq, 1'b0);
    pulse(1'b1, 1'b0);
    check("R1 no match at 00:00:01", alarmFlag, 1'b0);
    setTime(8'h00, 8'h00, 8'h00);
    pulse(1'b1, 1'b0);
    check("R1 match at 00:00:00", alarmFlag, 1'b1);

    // R7: sticky without acknowledge, then cleared
    setTime(8'h00, 8'h00, 8'h05);
    repeat (5) pulse(1'b1, 1'b0);
    check("R7 flag holds", alarmFlag, 1'b1);
    pulse(1'b0, 1'b1);
    check("R7 read clears", alarmFlag, 1'b0);

    // R6: match held without a tick
    setTime(8'h00, 8'h00, 8'h00);
    repeat (6) @(negedge clk);
    check("R6 no tick no set", alarmFlag, 1'b0);

    // R3/R4/R9: all mask patterns against all match patterns
    for (int mc = 0; mc < 8; mc++) begin
      writeReg(2'd0, {mc[0], 7'h56});
      writeReg(2'd1, {mc[1], 7'h34});
      writeReg(2'd2, {mc[2], 7'h12});
      for (int tc = 0; tc < 8; tc++) begin
        logic expF;
        expF = (mc[0] | tc[0]) & (mc[1] | tc[1]) & (mc[2] | tc[2]);
        pulse(1'b0, 1'b1);
        setTime(tc[2] ? 8'h12 : 8'h13, tc[1] ? 8'h34 : 8'h44, tc[0] ? 8'h56 : 8'h57);
        irqEnable = (tc % 3) != 0;
        pulse(1'b1, 1'b0);
        check("R3 R4 masked match sweep", alarmFlag, expF);
        check("R9 irq gating", alarmIrq, expF & irqEnable);
      end
    end
    irqEnable = 1'b1;

    // R5: everything masked fires on any tick
    writeReg(2'd0, 8'h80); writeReg(2'd1, 8'h80); writeReg(2'd2, 8'h80);
    pulse(1'b0, 1'b1);
    setTime(8'h23, 8'h59, 8'h41);
    pulse(1'b1, 1'b0);
    check("R5 all masked fires", alarmFlag, 1'b1);

    // R8: match and acknowledge together, flag set and flag clear
    pulse(1'b1, 1'b1);
    check("R8 set wins when flag set", alarmFlag, 1'b1);
    pulse(1'b0, 1'b1);
    check("R8 precondition cleared", alarmFlag, 1'b0);
    pulse(1'b1, 1'b1);
    check("R8 set wins when flag clear", alarmFlag, 1'b1);

    // R2: select 3 writes nothing; seconds alarm 0x10 stays
    writeReg(2'd0, 8'h10);
    writeReg(2'd3, 8'h20);
    pulse(1'b0, 1'b1);
    setTime(8'h00, 8'h00, 8'h20);
    pulse(1'b1, 1'b0);
    check("R2 select 3 ignored (0x20 no match)", alarmFlag, 1'b0);
    setTime(8'h00, 8'h00, 8'h10);
    pulse(1'b1, 1'b0);
    check("R2 seconds register intact", alarmFlag, 1'b1);

    // R3: sweep all seconds against alarm 37, others masked
    writeReg(2'd0, 8'h37);
    for (int s = 0; s < 60; s++) begin
      pulse(1'b0, 1'b1);
      setTime(8'h00, 8'h00, toBcd(s));
      pulse(1'b1, 1'b0);
      check("R3 seconds sweep", alarmFlag, s == 37);
    end

    // R10: hour bit 6 ignored on both sides
    writeReg(2'd0, 8'h80);
    writeReg(2'd2, 8'h52);
    pulse(1'b0, 1'b1);
    setTime(8'h12, 8'h00, 8'h00);
    pulse(1'b1, 1'b0);
    check("R10 register bit6 ignored", alarmFlag, 1'b1);
    writeReg(2'd2, 8'h12);
    pulse(1'b0, 1'b1);
    setTime(8'h52, 8'h00, 8'h00);
    pulse(1'b1, 1'b0);
    check("R10 time bit6 ignored", alarmFlag, 1'b1);
    pulse(1'b0, 1'b1);
    setTime(8'h22, 8'h00, 8'h00);
    pulse(1'b1, 1'b0);
    check("R10 hour tens still compared", alarmFlag, 1'b0);

    // R9: irq follows enable while the flag is set
    setTime(8'h12, 8'h00, 8'h00);
    pulse(1'b1, 1'b0);
    irqEnable = 1'b0;
    #1;
    check("R9 irq off when disabled", alarmIrq, 1'b0);
    irqEnable = 1'b1;
    #1;
    check("R9 irq on when enabled", alarmIrq, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule